// File: doc/BRIEF.md
# Wake Interrupt Polarity Conditioner

This block sits between a bank of raw, asynchronous wake-capable input pins and a downstream interrupt controller that accepts only active-high levels and rising edges. Each line gets its own trigger code and enable bit. Active-low levels are turned into active-high levels. Falling edges and dual edges are turned into single-cycle rising pulses. Every line's conditioned output is then gated by its enable bit.

Software programs the block through a word-addressed register port with single-cycle writes and registered reads. Each input line passes through a synchroniser. An edge detector then works on the synchronised copy of the line. The final output is registered.

A rewrite of a line's trigger code could let a stale edge reach the controller while the line is being reconfigured. To prevent this, each line has a two-state guard machine that blocks edge events around any write to that line's configuration word. The states and transitions are:
- GUARD_OPEN: edge events pass.
- GUARD_HOLD: edge events are blocked.
- GUARD_OPEN goes to GUARD_HOLD when the line's configuration word is written.
- GUARD_HOLD stays in GUARD_HOLD while writes to that word continue.
- GUARD_HOLD returns to GUARD_OPEN on the first cycle without such a write.

Level outputs are never blocked by the guard.

Top module: `wake_irq_conditioner`

## Requirements
- R1: After reset every enable bit reads 0, every trigger code reads 3'b100 and every conditioned output is low.
- R2: The enable bit of line n sits at bit n mod 32 of the word at byte offset 0x10 + 4*(n/32). The trigger code of line n sits in bits [2:0] of the word at byte offset 0x110 + 4*n, and the upper 29 bits of that word read as zero. Address bits [1:0] are ignored.
- R3: Read data appears on the clock edge after the address is presented. Any offset that is neither an enable word nor a configuration word of an existing line reads as zero.
- R4: Each input passes through two synchroniser flops and one output register. A change on an input that lands between two clock edges shows on the output after the third following rising edge.
- R5: Code 3'b100 (level, active-high) makes the output follow the input.
- R6: Code 3'b000 (level, active-low) makes the output the inverse of the input.
- R7: Code 3'b110 (rising edge) makes the output high for exactly one cycle for each low-to-high transition of the input.
- R8: Code 3'b010 (falling edge) makes the output high for exactly one cycle for each high-to-low transition of the input.
- R9: Code 3'b111 (both edges) makes the output high for one cycle for each transition of the input, in either direction.
- R10: Codes 3'b001, 3'b011 and 3'b101 are unsupported and hold the output low.
- R11: A line whose enable bit is 0 drives its output low from the first clock edge after the bit is cleared, whatever its input or code.
- R12: An edge event that would update the output on the clock edge that performs a write to the line's configuration word, or on the edge right after it, is discarded. Level outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| wake_in | input | NUM_LINES | Raw asynchronous wake inputs |
| irq_out | output | NUM_LINES | Conditioned active-high outputs |

## Verification
The bench builds the block with NUM_LINES = 64, ADDR_W = 12 and SYNC_DEPTH = 2. With 64 lines the enable bits span two words, so the packing of lines across a word boundary can be checked, and the highest configuration slot at 0x20C and the first unmapped offset after it at 0x210 can both be reached. A behavioural model covers all eight trigger codes, including the unsupported ones. It is driven by random toggling of the inputs mixed with random configuration and enable writes, so writes often land in the middle of an edge. Directed sequences place a configuration write exactly on the edge that would emit a pulse, and exactly one edge earlier.

// File: rtl/wic_pkg.sv
package wic_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'b000,
        TRIG_FALL   = 3'b010,
        TRIG_LVL_HI = 3'b100,
        TRIG_RISE   = 3'b110,
        TRIG_BOTH   = 3'b111
    } trig_e;

    typedef enum logic {
        GUARD_OPEN = 1'b0,
        GUARD_HOLD = 1'b1
    } guard_e;

    localparam int EN_BASE_BYTE  = 'h10;
    localparam int CFG_BASE_BYTE = 'h110;

    function automatic logic trig_is_edge(input logic [2:0] code);
        return (code == TRIG_FALL) || (code == TRIG_RISE) || (code == TRIG_BOTH);
    endfunction

    function automatic logic trig_is_supported(input logic [2:0] code);
        return trig_is_edge(code) || (code == TRIG_LVL_LO) || (code == TRIG_LVL_HI);
    endfunction

endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] chain_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[DEPTH-1];

endmodule

// File: rtl/wic_regfile.sv
module wic_regfile
    import wic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_en,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [NUM_LINES-1:0]   en_bits,
    output logic [3*NUM_LINES-1:0] cfg_flat,
    output logic [NUM_LINES-1:0]   cfg_hit
);

    localparam int EN_WORDS = (NUM_LINES + 31) / 32;
    localparam int WA_W     = ADDR_W - 2;
    localparam int EN_WA_I  = EN_BASE_BYTE / 4;
    localparam int CFG_WA_I = CFG_BASE_BYTE / 4;
    localparam logic [WA_W-1:0] EN_WA0 = WA_W'(EN_WA_I);

    logic [WA_W-1:0]        wa;
    logic [EN_WORDS*32-1:0] en_pad;
    logic [31:0]            rd_d;
    logic [31:0]            rdata_q;
    logic                   unused_addr_lsb;

    assign wa              = addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^addr[1:0];

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            localparam int WORD_IDX = n / 32;
            localparam int BIT_IDX  = n % 32;
            localparam logic [WA_W-1:0] EN_WA_N  = WA_W'(EN_WA_I + WORD_IDX);
            localparam logic [WA_W-1:0] CFG_WA_N = WA_W'(CFG_WA_I + n);

            logic       en_bit_q;
            logic [2:0] code_q;

            assign cfg_hit[n] = wr_en && (wa == CFG_WA_N);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          en_bit_q <= 1'b0;
                else if (wr_en && (wa == EN_WA_N))   en_bit_q <= wdata[BIT_IDX];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          code_q <= TRIG_LVL_HI;
                else if (cfg_hit[n]) code_q <= wdata[2:0];
            end

            assign en_bits[n]        = en_bit_q;
            assign cfg_flat[3*n +: 3] = code_q;
        end
    endgenerate

    assign en_pad = (EN_WORDS*32)'(en_bits);

    always_comb begin
        rd_d = '0;
        for (int k = 0; k < EN_WORDS; k++) begin
            if (wa == WA_W'(EN_WA_I + k)) rd_d = en_pad[k*32 +: 32];
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wa == WA_W'(CFG_WA_I + i)) rd_d = {29'b0, cfg_flat[3*i +: 3]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_d;
    end

    assign rdata = rdata_q;

    // R2: a write to the first enable word lands in line 0's enable bit
    a_r2_enable_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wa == EN_WA0)) |=> (en_bits[0] == $past(wdata[0])));

    // R3: offsets below the first enable word read as zero one cycle later
    a_r3_low_offsets_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wa < EN_WA0) |=> (rdata == 32'd0));

endmodule

// File: rtl/wic_line.sv
module wic_line
    import wic_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic       en,
    input  logic [2:0] cfg,
    input  logic       cfg_hit,
    output logic       irq_out
);

    logic   lvl_s;
    logic   lvl_p;
    logic   rise_ev;
    logic   fall_ev;
    logic   quiet;
    logic   cond;
    logic   irq_d;
    logic   irq_q;
    guard_e guard_q;
    guard_e guard_d;

    wic_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (lvl_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_p <= 1'b0;
        else        lvl_p <= lvl_s;
    end

    // guard state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) guard_q <= GUARD_OPEN;
        else        guard_q <= guard_d;
    end

    // guard next state
    always_comb begin
        guard_d = guard_q;
        unique case (guard_q)
            GUARD_OPEN: if (cfg_hit)  guard_d = GUARD_HOLD;
            GUARD_HOLD: if (!cfg_hit) guard_d = GUARD_OPEN;
        endcase
    end

    assign quiet   = cfg_hit || (guard_q == GUARD_HOLD);
    assign rise_ev = lvl_s & ~lvl_p;
    assign fall_ev = ~lvl_s & lvl_p;

    // output select
    always_comb begin
        case (cfg)
            TRIG_LVL_LO: cond = ~lvl_s;
            TRIG_LVL_HI: cond = lvl_s;
            TRIG_FALL:   cond = fall_ev & ~quiet;
            TRIG_RISE:   cond = rise_ev & ~quiet;
            TRIG_BOTH:   cond = (rise_ev | fall_ev) & ~quiet;
            default:     cond = 1'b0;
        endcase
        irq_d = en & cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_out = irq_q;

    // R11: a disabled line yields a low output on the next edge
    a_r11_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq_out);

    // R10: unsupported codes never raise the output
    a_r10_unsupported_low: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_is_supported(cfg) |=> !irq_out);

    // R12: a configuration write blocks edge-mode output on that edge
    a_r12_write_masks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && trig_is_edge(cfg)) |=> !irq_out);

    // R7: a rising-edge pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && (cfg == TRIG_RISE) && ($past(cfg) == TRIG_RISE)) |=> !irq_out);

endmodule

// File: rtl/wake_irq_conditioner.sv
module wake_irq_conditioner
    import wic_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter int ADDR_W     = 12,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] wake_in,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0]   en_bits;
    logic [3*NUM_LINES-1:0] cfg_flat;
    logic [NUM_LINES-1:0]   cfg_hit;

    wic_regfile #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr_en    (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .en_bits  (en_bits),
        .cfg_flat (cfg_flat),
        .cfg_hit  (cfg_hit)
    );

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_cond
            wic_line #(.SYNC_DEPTH(SYNC_DEPTH)) u_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_in  (wake_in[n]),
                .en      (en_bits[n]),
                .cfg     (cfg_flat[3*n +: 3]),
                .cfg_hit (cfg_hit[n]),
                .irq_out (irq_out[n])
            );
        end
    endgenerate

endmodule

// File: tb/sim_wake_irq_conditioner.sv
module sim_wake_irq_conditioner;

    localparam int N      = 64;
    localparam int AW     = 12;
    localparam int EN_W0  = 'h10 / 4;
    localparam int CFG_W0 = 'h110 / 4;
    localparam int EN_NW  = (N + 31) / 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] reg_addr;
    logic          reg_wr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  wake_in;
    logic [N-1:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wake_irq_conditioner #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_DEPTH(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wake_in   (wake_in),
        .irq_out   (irq_out)
    );

    // behavioural reference state
    bit [N-1:0] m_ff1, m_s, m_p, m_out, m_hold, m_en;
    bit [2:0]   m_cfg [N];
    bit [31:0]  m_rd;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input bit en, input bit [2:0] c);
        if (!en) return "R11";
        case (c)
            3'b000:  return "R6";
            3'b100:  return "R5";
            3'b010:  return "R8";
            3'b110:  return "R7";
            3'b111:  return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : ref_model
        int        wa;
        bit [31:0] nrd;
        bit        hit;
        bit        quiet;
        bit        v;
        bit [2:0]  c;
        if (!rst_n) begin
            m_ff1 = '0; m_s = '0; m_p = '0; m_out = '0; m_hold = '0; m_en = '0;
            for (int i = 0; i < N; i++) m_cfg[i] = 3'b100;
            m_rd = '0;
        end else begin
            wa  = int'(reg_addr) >> 2;
            nrd = '0;
            if (wa >= EN_W0 && wa < EN_W0 + EN_NW)
                for (int b = 0; b < 32; b++)
                    if ((wa - EN_W0) * 32 + b < N) nrd[b] = m_en[(wa - EN_W0) * 32 + b];
            if (wa >= CFG_W0 && wa < CFG_W0 + N) nrd = {29'b0, m_cfg[wa - CFG_W0]};
            for (int i = 0; i < N; i++) begin
                hit   = reg_wr && (wa == CFG_W0 + i);
                quiet = hit || m_hold[i];
                c     = m_cfg[i];
                case (c)
                    3'b000:  v = !m_s[i];
                    3'b100:  v = m_s[i];
                    3'b010:  v = !m_s[i] && m_p[i] && !quiet;
                    3'b110:  v = m_s[i] && !m_p[i] && !quiet;
                    3'b111:  v = (m_s[i] != m_p[i]) && !quiet;
                    default: v = 1'b0;
                endcase
                m_out[i]  = m_en[i] && v;
                m_p[i]    = m_s[i];
                m_s[i]    = m_ff1[i];
                m_ff1[i]  = wake_in[i];
                m_hold[i] = hit;
            end
            if (reg_wr && wa >= EN_W0 && wa < EN_W0 + EN_NW)
                for (int b = 0; b < 32; b++)
                    if ((wa - EN_W0) * 32 + b < N) m_en[(wa - EN_W0) * 32 + b] = reg_wdata[b];
            if (reg_wr && wa >= CFG_W0 && wa < CFG_W0 + N) m_cfg[wa - CFG_W0] = reg_wdata[2:0];
            m_rd = nrd;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int i = 0; i < N; i++)
                check(irq_out[i] === m_out[i], tag_of(m_en[i], m_cfg[i]),
                      32'(irq_out[i]), 32'(m_out[i]));
            check(reg_rdata === m_rd, "R3", reg_rdata, m_rd);
        end
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick(1);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        reg_wr   = 1'b0;
        tick(1);
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic bit_is(input int idx, input bit exp, input string tag);
        check(irq_out[idx] == exp, tag, 32'(irq_out[idx]), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; wake_in = '0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        tick(1);

        // R1 reset state
        check(irq_out == '0, "R1", irq_out[31:0], 32'd0);
        rd(12'h010, 32'd0, "R1");
        rd(12'h014, 32'd0, "R1");
        rd(12'h124, 32'd4, "R1");

        // R3 unmapped offsets
        rd(12'h000, 32'd0, "R3");
        rd(12'h018, 32'd0, "R3");
        rd(12'h10C, 32'd0, "R3");
        rd(12'h210, 32'd0, "R3");

        // R2 map and field positions
        wr(12'h014, 32'hA5A5_0003);
        rd(12'h014, 32'hA5A5_0003, "R2");
        wr(12'h20C, 32'hFFFF_FFF6);
        rd(12'h20C, 32'd6, "R2");
        wr(12'h113, 32'h0000_0002);
        rd(12'h110, 32'd2, "R2");

        // line setup: 0 high, 1 low, 2 rise, 3 fall, 4 both, 5 unsupported
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h110, 32'd4);
        wr(12'h114, 32'd0);
        wr(12'h118, 32'd6);
        wr(12'h11C, 32'd2);
        wr(12'h120, 32'd7);
        wr(12'h124, 32'd3);
        tick(4);
        bit_is(1, 1'b1, "R6");

        wake_in[5:0] = 6'h3F;
        tick(2);
        bit_is(0, 1'b0, "R4");
        tick(1);
        bit_is(0, 1'b1, "R4");
        bit_is(0, 1'b1, "R5");
        bit_is(2, 1'b1, "R7");
        bit_is(4, 1'b1, "R9");
        bit_is(3, 1'b0, "R8");
        bit_is(1, 1'b0, "R6");
        bit_is(5, 1'b0, "R10");
        tick(1);
        bit_is(2, 1'b0, "R7");
        bit_is(4, 1'b0, "R9");
        bit_is(0, 1'b1, "R5");

        wake_in[5:0] = 6'h00;
        tick(3);
        bit_is(3, 1'b1, "R8");
        bit_is(4, 1'b1, "R9");
        bit_is(2, 1'b0, "R7");
        bit_is(0, 1'b0, "R5");
        bit_is(1, 1'b1, "R6");
        bit_is(5, 1'b0, "R10");
        tick(1);
        bit_is(3, 1'b0, "R8");

        // R11 disable line 1 (active-low level, input low)
        wr(12'h010, 32'hFFFF_FFFD);
        bit_is(1, 1'b1, "R11");
        tick(1);
        bit_is(1, 1'b0, "R11");

        // R12 write on the edge that would emit a rising pulse
        wake_in[2] = 1'b1;
        tick(2);
        wr(12'h118, 32'd6);
        bit_is(2, 1'b0, "R12");
        tick(1);
        bit_is(2, 1'b0, "R12");

        // R12 write one edge before a falling pulse
        wake_in[3] = 1'b1;
        tick(5);
        wake_in[3] = 1'b0;
        tick(1);
        wr(12'h11C, 32'd2);
        tick(1);
        bit_is(3, 1'b0, "R12");
        tick(1);
        bit_is(3, 1'b0, "R12");

        // mixed random traffic, compared cycle by cycle against the model
        for (int it = 0; it < 4000; it++) begin
            wake_in = wake_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            if ($urandom_range(0, 5) == 0) begin
                int r = $urandom_range(0, 9);
                reg_wr = 1'b1;
                if (r < 7) begin
                    reg_addr  = AW'('h110 + 4 * $urandom_range(0, N - 1));
                    reg_wdata = $urandom;
                end else if (r < 9) begin
                    reg_addr  = AW'('h10 + 4 * $urandom_range(0, EN_NW - 1));
                    reg_wdata = $urandom | $urandom;
                end else begin
                    reg_addr  = AW'($urandom);
                    reg_wdata = $urandom;
                end
            end else begin
                reg_wr   = 1'b0;
                reg_addr = AW'($urandom_range(0, 'h220));
            end
            tick(1);
        end
        reg_wr = 1'b0;
        tick(3);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule